// File: doc/BRIEF.md
# GPIO Input Bank with Debounce Filtering and Edge Interrupts

This block receives a bank of general-purpose input pins and turns each one into a clean level and an interrupt source. Every pin passes through a two-flop synchronizer. A pin whose filter bit is set also goes through a stability filter. The filter accepts a new level only after the synchronized input has held that level for a programmed number of debounce-clock ticks. One 8-bit filter time applies to the whole bank. The ticks come from a slow debounce clock with a gate. Each tick is detected on the bank's functional clock, so all state sits in one clock domain.

Each filtered level feeds an edge detector. Independent rising and falling masks decide which transitions set a sticky status bit. Software clears a status bit by writing a one to it. A single interrupt line is high while any status bit is set and also enabled. All configuration goes through a plain register port with a combinational read.

Top module: `gpio_dbnc_bank`

## Requirements
- R1: After reset every register reads 0 and `irq_o` is low.
- R2: A pin whose filter bit is clear records its edge in the status register within 4 functional clock cycles of the input change. Its filtered level reads back at address 6 within the same time.
- R3: Rising mask (address 2) and falling mask (address 3) act per pin, independently. A pin with both bits set records either edge. A pin with neither bit set records nothing.
- R4: Status bits (address 5) are sticky. Writing 1 to a bit clears it. Writing 0 leaves it unchanged. An edge arriving in the same cycle as the clear wins.
- R5: `irq_o` is high exactly when some bit is set in both the status register and the interrupt-enable register (address 4).
- R6: A pin with its filter bit set (address 1) changes its filtered level only after the synchronized input has been stable for (time + 1) debounce ticks. The time register is at address 0. A tick is a rising edge of `dbclk_i` while `dbclk_gate_i` is high.
- R7: A level that does not stay stable for the full filter period is rejected. The filtered level and the status bits stay unchanged.
- R8: While `dbclk_gate_i` is low, a filtered pin keeps its filtered level no matter what its input does. It resumes filtering once the gate returns high.
- R9: The filter time register keeps 8 bits. Write data above bit 7 is dropped, and the upper read bits are 0. The mask registers read back exactly as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Functional clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| dbclk_i | input | 1 | Slow debounce clock, sampled as data |
| dbclk_gate_i | input | 1 | Debounce clock gate, high to let ticks through |
| pins_i | input | 32 | Raw pin inputs |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data, combinational |
| irq_o | output | 1 | Bank interrupt |

## Verification
The bench holds a filtered pin's new level for less than the full period and checks that the level is still old. A filter that counted from the wrong start, or counted cycles instead of ticks, would switch too early. Pulses and fast toggling shorter than the period must produce neither a level change nor status. A design that did not restart its count on every input change would let them through. With the gate closed, the bench changes the input and checks that the level holds. The level must move only after the gate reopens, which catches a filter that ignores the gate. Clear-versus-sticky behaviour is checked with partial write-one patterns and with zero writes.

// File: rtl/gpio_dbnc_pkg.sv
package gpio_dbnc_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_DBTIME = 3'd0,
    REG_DBEN   = 3'd1,
    REG_RISE   = 3'd2,
    REG_FALL   = 3'd3,
    REG_IRQEN  = 3'd4,
    REG_STAT   = 3'd5,
    REG_LEVEL  = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/gpio_dbnc_tick.sv
module gpio_dbnc_tick (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic dbclk_i,
  input  logic gate_i,
  output logic tick_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= dbclk_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign tick_o = s2_q & ~s3_q & gate_i;
endmodule

// File: rtl/gpio_dbnc_pin.sv
module gpio_dbnc_pin #(
  parameter int TIME_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              din_i,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic [TIME_W-1:0] time_i,
  output logic              filt_o
);
  logic s1_q, s2_q, s3_q, filt_q;
  logic [TIME_W-1:0] cnt_q, lim_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      s3_q   <= 1'b0;
      filt_q <= 1'b0;
      cnt_q  <= '0;
      lim_q  <= '0;
    end else begin
      s1_q <= din_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
      if (!en_i) begin
        filt_q <= s2_q;
        cnt_q  <= '0;
        lim_q  <= time_i;
      end else if (s2_q != s3_q || s2_q == filt_q) begin
        // input moved or settled back: restart, pick up current time
        cnt_q <= '0;
        lim_q <= time_i;
      end else if (tick_i) begin
        if (cnt_q == lim_q) begin
          filt_q <= s2_q;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign filt_o = filt_q;

  AST_GATED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) |=> $stable(filt_q)); // R8
  AST_NO_EARLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && s2_q != s3_q) |=> $stable(filt_q)); // R6
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= lim_q); // R6
endmodule

// File: rtl/gpio_dbnc_edge.sv
module gpio_dbnc_edge #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] filt_i,
  input  logic [NUM_PINS-1:0] rise_i,
  input  logic [NUM_PINS-1:0] fall_i,
  output logic [NUM_PINS-1:0] evt_o
);
  logic [NUM_PINS-1:0] filt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) filt_q <= '0;
    else         filt_q <= filt_i;
  end

  assign evt_o = (rise_i & filt_i & ~filt_q) | (fall_i & ~filt_i & filt_q);

  AST_EDGE_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o & ~(rise_i | fall_i)) == '0); // R3
endmodule

// File: rtl/gpio_dbnc_regs.sv
module gpio_dbnc_regs
  import gpio_dbnc_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int TIME_W   = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] rdata_o,
  input  logic [NUM_PINS-1:0] level_i,
  input  logic [NUM_PINS-1:0] evt_i,
  output logic [TIME_W-1:0]   time_o,
  output logic [NUM_PINS-1:0] dben_o,
  output logic [NUM_PINS-1:0] rise_o,
  output logic [NUM_PINS-1:0] fall_o,
  output logic                irq_o
);
  localparam int PAD_W = NUM_PINS - TIME_W;

  logic [TIME_W-1:0]   time_q;
  logic [NUM_PINS-1:0] dben_q, rise_q, fall_q, irqen_q, stat_q, clr;
  logic                wr_stat;

  assign wr_stat = we_i && (addr_i == REG_STAT);
  assign clr     = wr_stat ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      time_q  <= '0;
      dben_q  <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
      irqen_q <= '0;
      stat_q  <= '0;
    end else begin
      stat_q <= (stat_q & ~clr) | evt_i;
      if (we_i) begin
        unique case (addr_i)
          REG_DBTIME: time_q  <= wdata_i[TIME_W-1:0];
          REG_DBEN:   dben_q  <= wdata_i;
          REG_RISE:   rise_q  <= wdata_i;
          REG_FALL:   fall_q  <= wdata_i;
          REG_IRQEN:  irqen_q <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (addr_i)
      REG_DBTIME: rdata_o = {{PAD_W{1'b0}}, time_q};
      REG_DBEN:   rdata_o = dben_q;
      REG_RISE:   rdata_o = rise_q;
      REG_FALL:   rdata_o = fall_q;
      REG_IRQEN:  rdata_o = irqen_q;
      REG_STAT:   rdata_o = stat_q;
      REG_LEVEL:  rdata_o = level_i;
      default:    rdata_o = '0;
    endcase
  end

  assign time_o = time_q;
  assign dben_o = dben_q;
  assign rise_o = rise_q;
  assign fall_o = fall_q;
  assign irq_o  = |(stat_q & irqen_q);

  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_stat |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R4
  AST_W1C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_stat |=> ((stat_q & $past(wdata_i) & ~$past(evt_i)) == '0)); // R4
endmodule

// File: rtl/gpio_dbnc_bank.sv
module gpio_dbnc_bank
  import gpio_dbnc_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int TIME_W   = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                dbclk_i,
  input  logic                dbclk_gate_i,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] rdata_o,
  output logic                irq_o
);
  logic                tick;
  logic [TIME_W-1:0]   db_time;
  logic [NUM_PINS-1:0] dben, rise, fall, filt, evt;

  gpio_dbnc_tick u_tick (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .dbclk_i (dbclk_i),
    .gate_i  (dbclk_gate_i),
    .tick_o  (tick)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    gpio_dbnc_pin #(.TIME_W(TIME_W)) u_pin (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .din_i  (pins_i[i]),
      .en_i   (dben[i]),
      .tick_i (tick),
      .time_i (db_time),
      .filt_o (filt[i])
    );
  end

  gpio_dbnc_edge #(.NUM_PINS(NUM_PINS)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .filt_i (filt),
    .rise_i (rise),
    .fall_i (fall),
    .evt_o  (evt)
  );

  gpio_dbnc_regs #(.NUM_PINS(NUM_PINS), .TIME_W(TIME_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .level_i (filt),
    .evt_i   (evt),
    .time_o  (db_time),
    .dben_o  (dben),
    .rise_o  (rise),
    .fall_o  (fall),
    .irq_o   (irq_o)
  );
endmodule

// File: tb/gpio_dbnc_bank_bench.sv
`timescale 1ns/1ps
module gpio_dbnc_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dbclk = 1'b0;
  logic        gate = 1'b0;
  logic [31:0] pins = '0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  always #20 dbclk = ~dbclk;  // tick every 8 functional cycles

  gpio_dbnc_bank u_gpio_dbnc_bank (
    .clk_i (clk), .rst_ni (rst_n), .dbclk_i (dbclk), .dbclk_gate_i (gate),
    .pins_i (pins), .we_i (we), .addr_i (addr), .wdata_i (wdata),
    .rdata_o (rdata), .irq_o (irq)
  );

  typedef struct packed {
    logic [31:0] a, b, rise, fall, exp;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_FFFF, 32'hFFFF_0000, 32'h0000_FFFF},
    '{32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_FFFF, 32'hFFFF_0000, 32'hFFFF_0000},
    '{32'h0F0F_0F0F, 32'hF0F0_F0F0, 32'hFFFF_FFFF, 32'h0000_0000, 32'hF0F0_F0F0},
    '{32'h0F0F_0F0F, 32'hF0F0_F0F0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    '{32'h0000_0000, 32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0000}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] r;
    cyc(5);
    rst_n = 1'b1;
    cyc(3);
    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), r);
      check("R1 reset register", r, 32'h0);
    end
    check("R1 irq after reset", {31'b0, irq}, 32'h0);

    // R9 time width and mask readback
    wr(3'd0, 32'h0000_01FF);
    rd(3'd0, r); check("R9 time truncated", r, 32'h0000_00FF);
    wr(3'd0, 32'h0);
    wr(3'd2, 32'hA5A5_5A5A);
    rd(3'd2, r); check("R9 rise readback", r, 32'hA5A5_5A5A);
    wr(3'd3, 32'h1234_8765);
    rd(3'd3, r); check("R9 fall readback", r, 32'h1234_8765);

    // R2 R3 R5 vector table, all pins unfiltered
    for (int i = 0; i < 5; i++) begin
      wr(3'd2, 32'h0); wr(3'd3, 32'h0); wr(3'd4, 32'h0);
      pins = VEC[i].a;
      cyc(6);
      wr(3'd5, 32'hFFFF_FFFF);
      wr(3'd2, VEC[i].rise); wr(3'd3, VEC[i].fall);
      @(negedge clk);
      pins = VEC[i].b;
      cyc(4);
      rd(3'd5, r); check("R2 R3 status after edges", r, VEC[i].exp);
      rd(3'd6, r); check("R2 unfiltered level", r, VEC[i].b);
      wr(3'd4, 32'hFFFF_FFFF);
      cyc(1);
      check("R5 irq with all enabled", {31'b0, irq}, {31'b0, (VEC[i].exp != 0)});
    end

    // R4 W1C and sticky, R5 masking
    wr(3'd2, 32'h0); wr(3'd3, 32'h0); wr(3'd4, 32'h0);
    pins = '0; cyc(6);
    wr(3'd5, 32'hFFFF_FFFF);
    wr(3'd2, 32'hFFFF_FFFF);
    pins = 32'hFFFF_FFFF; cyc(6);
    wr(3'd5, 32'h0000_00FF);
    rd(3'd5, r); check("R4 partial clear", r, 32'hFFFF_FF00);
    wr(3'd5, 32'h0);
    cyc(10);
    rd(3'd5, r); check("R4 zero write and sticky", r, 32'hFFFF_FF00);
    wr(3'd4, 32'h0000_00FF); cyc(1);
    check("R5 irq masked by enable", {31'b0, irq}, 32'h0);
    wr(3'd4, 32'h0000_0100); cyc(1);
    check("R5 irq enabled bit set", {31'b0, irq}, 32'h1);
    wr(3'd5, 32'hFFFF_FFFF); cyc(1);
    check("R4 R5 irq after full clear", {31'b0, irq}, 32'h0);

    // R6 filtered pin 0, time 7 -> 8 ticks = 64 cycles
    wr(3'd2, 32'h0); wr(3'd4, 32'h0);
    pins = '0; cyc(6);
    gate = 1'b1;
    wr(3'd1, 32'h1); wr(3'd0, 32'd7);
    wr(3'd2, 32'h1); wr(3'd3, 32'h1);
    wr(3'd5, 32'hFFFF_FFFF);
    cyc(20);
    @(negedge clk); pins[0] = 1'b1;
    cyc(30);
    rd(3'd6, r); check("R6 level held before period", r & 32'h1, 32'h0);
    rd(3'd5, r); check("R6 no status before period", r, 32'h0);
    cyc(90);
    rd(3'd6, r); check("R6 level after period", r & 32'h1, 32'h1);
    rd(3'd5, r); check("R6 status after period", r, 32'h1);
    wr(3'd5, 32'hFFFF_FFFF);

    // R7 short low pulse and fast toggling are rejected
    @(negedge clk); pins[0] = 1'b0;
    cyc(30);
    @(negedge clk); pins[0] = 1'b1;
    cyc(150);
    rd(3'd6, r); check("R7 pulse level unchanged", r & 32'h1, 32'h1);
    rd(3'd5, r); check("R7 pulse no status", r, 32'h0);
    for (int t = 0; t < 20; t++) begin
      @(negedge clk); pins[0] = ~pins[0];
      cyc(10);
    end
    cyc(150);
    rd(3'd6, r); check("R7 toggle level unchanged", r & 32'h1, 32'h1);
    rd(3'd5, r); check("R7 toggle no status", r, 32'h0);

    // R8 gate closed holds, reopening resumes (time 0 -> 1 tick)
    wr(3'd0, 32'd0);
    gate = 1'b0;
    @(negedge clk); pins[0] = 1'b0;
    cyc(100);
    rd(3'd6, r); check("R8 level held while gated", r & 32'h1, 32'h1);
    rd(3'd5, r); check("R8 no status while gated", r, 32'h0);
    gate = 1'b1;
    cyc(40);
    rd(3'd6, r); check("R8 level after gate opens", r & 32'h1, 32'h0);
    rd(3'd5, r); check("R8 status after gate opens", r, 32'h1);

    done = 1;
    finish_run();
  end
endmodule